// File: doc/BRIEF.md
# Stale Victim Request Filter

This block sits in front of a coherence directory's request decoder and screens eviction (victim) requests. It holds an ignore vector for each cache line, with one bit for each requestor. A probe response from a requestor can mark that requestor's bit on a line. A victim that the requestor sends later for that line has then been overtaken by the probe. Its data is already accounted for, so the filter sinks it instead of passing it to the directory.

Every victim request, dirty or clean, is looked up on its line and requestor. On a hit the filter consumes the request, clears the bit and returns a writeback acknowledgement to the requestor one cycle later. Nothing goes to the directory and its state stays as it is, even when the line is in a blocked transient state. On a miss the request is handled by the state of its line:
- An open line forwards the request unchanged.
- A blocked line leaves the request at the head of the input.
- A line waiting on a writeback takes the request off the input and sends it back to the tail of the request queue.

Top module: `stale_victim_filter`

## Requirements
- R1: After reset every ignore bit is clear, `ackValid` is 0, and with `vicValid` low the outputs `vicReady`, `fwdValid` and `recycleValid` are all 0.
- R2: A cycle with `markValid` high sets the ignore bit for (`markLine`, `markReq`). A dirty victim (`vicDirty`=1) from that requestor on that line is then consumed without being forwarded.
- R3: A clean victim (`vicDirty`=0) is checked against the ignore vector in the same way as a dirty one.
- R4: When a victim hits a set bit, `vicReady` is 1 in that same cycle. In the following cycle `ackValid` is 1 for exactly one cycle, with `ackLine`/`ackReq` equal to the victim's line and requestor.
- R5: A victim that hits a set bit clears that bit. A later identical victim on an open line is forwarded.
- R6: A hitting victim is consumed and acknowledged for every `lineState` value (00 open, 01 blocked, 10 writeback pending, 11 blocked). It raises neither `fwdValid` nor `recycleValid`.
- R7: A victim that misses on an open line (`lineState`=00) raises `fwdValid` and `vicReady` in the same cycle. `fwdDirty`/`fwdLine`/`fwdReq` equal the inputs, and no acknowledgement follows.
- R8: A victim that misses on a blocked line (`lineState` 01 or 11) is held: `vicReady`, `fwdValid` and `recycleValid` stay 0 and no acknowledgement follows.
- R9: A victim that misses on a writeback-pending line (`lineState`=10) raises `vicReady` and `recycleValid` with `fwdValid` 0, and no acknowledgement follows.
- R10: Ignore bits are independent per (line, requestor). A mark does not affect another requestor on the same line, or the same requestor on another line.
- R11: When a mark and a hit's clear address the same bit in one cycle, the clear wins and the bit ends clear. When they address different bits, both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| markValid | input | 1 | Probe response asks to sink a pending victim |
| markLine | input | LINE_W | Line index of the mark |
| markReq | input | REQ_W | Requestor of the mark |
| vicValid | input | 1 | Victim request present at the input head |
| vicDirty | input | 1 | 1 for a dirty victim, 0 for a clean one |
| vicLine | input | LINE_W | Line index of the victim |
| vicReq | input | REQ_W | Requestor of the victim |
| lineState | input | 2 | Directory state of the victim's line: 00 open, 01/11 blocked, 10 writeback pending |
| vicReady | output | 1 | Victim is consumed this cycle |
| fwdValid | output | 1 | Victim passed to the directory as a normal victim |
| fwdDirty | output | 1 | Dirty flag of the forwarded victim |
| fwdLine | output | LINE_W | Line of the forwarded victim |
| fwdReq | output | REQ_W | Requestor of the forwarded victim |
| recycleValid | output | 1 | Victim sent back to the tail of the request queue |
| ackValid | output | 1 | Writeback acknowledgement for a sunk victim |
| ackLine | output | LINE_W | Line of the acknowledged victim |
| ackReq | output | REQ_W | Requestor receiving the acknowledgement |

## Verification
A probe mark and the clear caused by a sunk victim can land in the same cycle. The bench provokes this in two ways. First it marks a bit, then in one cycle it remarks that bit while the victim that consumes it arrives. It then sends the victim again on an open line and expects it to be forwarded, which shows the clear won. Second, a mark of a different bit shares a cycle with a hit. A later victim on each bit must be sunk and forwarded respectively.

// File: rtl/svf_pkg.sv
package svf_pkg;

  typedef enum logic [1:0] {
    LS_OPEN    = 2'b00,
    LS_BLOCKED = 2'b01,
    LS_WBPEND  = 2'b10,
    LS_HELD    = 2'b11
  } lineState_e;

  typedef struct packed {
    logic setMark;
    logic clearMark;
    logic loadAck;
    logic forward;
    logic recycle;
    logic accept;
  } filterStrobe_t;

endpackage

// File: rtl/svf_ctrl.sv
module svf_ctrl
  import svf_pkg::*;
(
  input  logic          markValid,
  input  logic          vicValid,
  input  logic          ignoreHit,
  input  lineState_e    lineState,
  output filterStrobe_t strobe
);

  logic staleHit;
  logic missOpen;
  logic missWbPend;

  always_comb begin
    staleHit   = vicValid && ignoreHit;
    missOpen   = vicValid && !ignoreHit && (lineState == LS_OPEN);
    missWbPend = vicValid && !ignoreHit && (lineState == LS_WBPEND);

    strobe.setMark   = markValid;
    strobe.clearMark = staleHit;
    strobe.loadAck   = staleHit;
    strobe.forward   = missOpen;
    strobe.recycle   = missWbPend;
    strobe.accept    = staleHit || missOpen || missWbPend;
  end

endmodule

// File: rtl/svf_datapath.sv
module svf_datapath
  import svf_pkg::*;
#(
  parameter int NUM_LINES = 16,
  parameter int NUM_REQ   = 4,
  parameter int LINE_W    = $clog2(NUM_LINES),
  parameter int REQ_W     = $clog2(NUM_REQ)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  filterStrobe_t     strobe,
  input  logic [LINE_W-1:0] markLine,
  input  logic [REQ_W-1:0]  markReq,
  input  logic [LINE_W-1:0] vicLine,
  input  logic [REQ_W-1:0]  vicReq,
  output logic              ignoreHit,
  output logic              ackValid,
  output logic [LINE_W-1:0] ackLine,
  output logic [REQ_W-1:0]  ackReq
);

  logic [NUM_REQ-1:0] ignoreRow [NUM_LINES];

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    logic [NUM_REQ-1:0] rowNext;

    always_comb begin
      rowNext = ignoreRow[g];
      for (int j = 0; j < NUM_REQ; j++) begin
        if (strobe.clearMark && vicLine == LINE_W'(g) && vicReq == REQ_W'(j)) begin
          rowNext[j] = 1'b0;
        end else if (strobe.setMark && markLine == LINE_W'(g) && markReq == REQ_W'(j)) begin
          rowNext[j] = 1'b1;
        end
      end
    end

    always_ff @(posedge clk) begin
      if (!rst_n) ignoreRow[g] <= '0;
      else        ignoreRow[g] <= rowNext;
    end
  end

  assign ignoreHit = ignoreRow[vicLine][vicReq];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ackValid <= 1'b0;
      ackLine  <= '0;
      ackReq   <= '0;
    end else begin
      ackValid <= strobe.loadAck;
      if (strobe.loadAck) begin
        ackLine <= vicLine;
        ackReq  <= vicReq;
      end
    end
  end

endmodule

// File: rtl/stale_victim_filter.sv
module stale_victim_filter
  import svf_pkg::*;
#(
  parameter int NUM_LINES = 16,
  parameter int NUM_REQ   = 4,
  parameter int LINE_W    = $clog2(NUM_LINES),
  parameter int REQ_W     = $clog2(NUM_REQ)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              markValid,
  input  logic [LINE_W-1:0] markLine,
  input  logic [REQ_W-1:0]  markReq,
  input  logic              vicValid,
  input  logic              vicDirty,
  input  logic [LINE_W-1:0] vicLine,
  input  logic [REQ_W-1:0]  vicReq,
  input  logic [1:0]        lineState,
  output logic              vicReady,
  output logic              fwdValid,
  output logic              fwdDirty,
  output logic [LINE_W-1:0] fwdLine,
  output logic [REQ_W-1:0]  fwdReq,
  output logic              recycleValid,
  output logic              ackValid,
  output logic [LINE_W-1:0] ackLine,
  output logic [REQ_W-1:0]  ackReq
);

  filterStrobe_t strobe;
  logic          ignoreHit;

  svf_ctrl u_ctrl (
    .markValid (markValid),
    .vicValid  (vicValid),
    .ignoreHit (ignoreHit),
    .lineState (lineState_e'(lineState)),
    .strobe    (strobe)
  );

  svf_datapath #(
    .NUM_LINES (NUM_LINES),
    .NUM_REQ   (NUM_REQ),
    .LINE_W    (LINE_W),
    .REQ_W     (REQ_W)
  ) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .strobe    (strobe),
    .markLine  (markLine),
    .markReq   (markReq),
    .vicLine   (vicLine),
    .vicReq    (vicReq),
    .ignoreHit (ignoreHit),
    .ackValid  (ackValid),
    .ackLine   (ackLine),
    .ackReq    (ackReq)
  );

  assign vicReady     = strobe.accept;
  assign fwdValid     = strobe.forward;
  assign recycleValid = strobe.recycle;
  assign fwdDirty     = vicDirty;
  assign fwdLine      = vicLine;
  assign fwdReq       = vicReq;

endmodule

// File: rtl/stale_victim_filter_chk.sv
module stale_victim_filter_chk #(
  parameter int LINE_W = 4,
  parameter int REQ_W  = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              vicValid,
  input logic [LINE_W-1:0] vicLine,
  input logic [REQ_W-1:0]  vicReq,
  input logic [1:0]        lineState,
  input logic              vicReady,
  input logic              fwdValid,
  input logic              recycleValid,
  input logic              ackValid,
  input logic [LINE_W-1:0] ackLine,
  input logic [REQ_W-1:0]  ackReq
);

  // R7
  fwd_open_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fwdValid |-> (vicValid && vicReady && lineState == 2'b00));

  // R9
  recycle_wbpend_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    recycleValid |-> (vicValid && vicReady && !fwdValid && lineState == 2'b10));

  // R8
  hold_blocked_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vicValid && !vicReady) |-> (lineState == 2'b01 || lineState == 2'b11));

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !vicValid |-> (!vicReady && !fwdValid && !recycleValid));

  // R4
  sunk_ack_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vicValid && vicReady && !fwdValid && !recycleValid) |=>
      (ackValid && ackLine == $past(vicLine) && ackReq == $past(vicReq)));

  // R6
  ack_has_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ackValid |-> $past(vicValid && vicReady && !fwdValid && !recycleValid));

endmodule

bind stale_victim_filter stale_victim_filter_chk #(
  .LINE_W (LINE_W),
  .REQ_W  (REQ_W)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .vicValid     (vicValid),
  .vicLine      (vicLine),
  .vicReq       (vicReq),
  .lineState    (lineState),
  .vicReady     (vicReady),
  .fwdValid     (fwdValid),
  .recycleValid (recycleValid),
  .ackValid     (ackValid),
  .ackLine      (ackLine),
  .ackReq       (ackReq)
);

// File: tb/stale_victim_filter_bench.sv
module stale_victim_filter_bench;

  localparam int NUM_LINES = 16;
  localparam int NUM_REQ   = 4;
  localparam int LINE_W    = $clog2(NUM_LINES);
  localparam int REQ_W     = $clog2(NUM_REQ);
  localparam logic [1:0] OPEN = 2'b00, BLK = 2'b01, WBP = 2'b10, BLK2 = 2'b11;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic markValid = 1'b0;
  logic [LINE_W-1:0] markLine = '0;
  logic [REQ_W-1:0]  markReq = '0;
  logic vicValid = 1'b0;
  logic vicDirty = 1'b0;
  logic [LINE_W-1:0] vicLine = '0;
  logic [REQ_W-1:0]  vicReq = '0;
  logic [1:0] lineState = 2'b00;
  logic vicReady, fwdValid, fwdDirty, recycleValid, ackValid;
  logic [LINE_W-1:0] fwdLine, ackLine;
  logic [REQ_W-1:0]  fwdReq, ackReq;

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  bit model [NUM_LINES][NUM_REQ];
  logic [LINE_W+REQ_W-1:0] ackQ [$];
  string ackTag [$];

  always #2 clk = ~clk;

  stale_victim_filter #(.NUM_LINES(NUM_LINES), .NUM_REQ(NUM_REQ)) u_stale_victim_filter (
    .clk(clk), .rst_n(rst_n),
    .markValid(markValid), .markLine(markLine), .markReq(markReq),
    .vicValid(vicValid), .vicDirty(vicDirty), .vicLine(vicLine), .vicReq(vicReq),
    .lineState(lineState),
    .vicReady(vicReady), .fwdValid(fwdValid), .fwdDirty(fwdDirty),
    .fwdLine(fwdLine), .fwdReq(fwdReq), .recycleValid(recycleValid),
    .ackValid(ackValid), .ackLine(ackLine), .ackReq(ackReq)
  );

  task automatic check(input string tag, input int actual, input int expected, input string what);
    compared++;
    if (actual != expected) begin
      mismatched++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, actual, expected);
    end
  endtask

  // Monitor: every acknowledgement must match the queue head, in the cycle predicted.
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (ackValid) begin
        if (ackQ.size() == 0) begin
          check("R4", 1, 0, "unexpected ackValid");
        end else begin
          logic [LINE_W+REQ_W-1:0] exp;
          string t;
          exp = ackQ.pop_front();
          t = ackTag.pop_front();
          check(t, int'({ackLine, ackReq}), int'(exp), "ack line/req");
        end
      end else if (ackQ.size() != 0) begin
        string t;
        void'(ackQ.pop_front());
        t = ackTag.pop_front();
        check(t, 0, 1, "missing ackValid");
      end
    end
  end

  // Driver: one cycle of stimulus with predictions from the requirement model.
  task automatic step(input bit mv, input int ml, input int mr,
                      input bit vv, input bit vd, input int vl, input int vr,
                      input logic [1:0] st, input string tag);
    bit hit, expReady, expFwd, expRec;
    @(negedge clk);
    markValid = mv; markLine = LINE_W'(ml); markReq = REQ_W'(mr);
    vicValid = vv; vicDirty = vd; vicLine = LINE_W'(vl); vicReq = REQ_W'(vr);
    lineState = st;
    #1;
    hit      = vv && model[vl][vr];
    expFwd   = vv && !hit && st == OPEN;
    expRec   = vv && !hit && st == WBP;
    expReady = hit || expFwd || expRec;
    check(tag, int'(vicReady), int'(expReady), "vicReady");
    check(tag, int'(fwdValid), int'(expFwd), "fwdValid");
    check(tag, int'(recycleValid), int'(expRec), "recycleValid");
    if (expFwd) begin
      check(tag, int'({fwdDirty, fwdLine, fwdReq}), int'({vd, LINE_W'(vl), REQ_W'(vr)}), "fwd fields");
    end
    if (hit) begin
      ackQ.push_back({LINE_W'(vl), REQ_W'(vr)});
      ackTag.push_back(tag);
    end
    if (mv) model[ml][mr] = 1'b1;
    if (hit) model[vl][vr] = 1'b0;
  endtask

  task automatic idle();
    step(0, 0, 0, 0, 0, 0, 0, OPEN, "R1");
  endtask

  initial begin
    for (int l = 0; l < NUM_LINES; l++)
      for (int r = 0; r < NUM_REQ; r++) model[l][r] = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R1", int'(ackValid), 0, "ackValid after reset");
    idle();
    // R1: every bit clear after reset, so victims from all requestors are forwarded
    for (int r = 0; r < NUM_REQ; r++) step(0, 0, 0, 1, 1, 3, r, OPEN, "R1");
    // R7: miss on open line
    step(0, 0, 0, 1, 0, 12, 2, OPEN, "R7");
    // R2 / R4: mark, then a dirty victim is sunk and acknowledged
    step(1, 3, 1, 0, 0, 0, 0, OPEN, "R2");
    step(0, 0, 0, 1, 1, 3, 1, OPEN, "R2");
    idle();
    // R5: bit cleared, same victim forwarded now
    step(0, 0, 0, 1, 1, 3, 1, OPEN, "R5");
    // R3: clean victim also checked
    step(1, 5, 2, 0, 0, 0, 0, OPEN, "R3");
    step(0, 0, 0, 1, 0, 5, 2, OPEN, "R3");
    // R10: independence of bits
    step(1, 7, 0, 0, 0, 0, 0, OPEN, "R10");
    step(0, 0, 0, 1, 1, 7, 1, OPEN, "R10");
    step(0, 0, 0, 1, 1, 6, 0, OPEN, "R10");
    // R6: sunk in blocked, held-blocked and writeback-pending states
    step(0, 0, 0, 1, 1, 7, 0, BLK, "R6");
    step(1, 2, 3, 0, 0, 0, 0, OPEN, "R6");
    step(0, 0, 0, 1, 0, 2, 3, WBP, "R6");
    step(1, 9, 1, 0, 0, 0, 0, OPEN, "R6");
    step(0, 0, 0, 1, 1, 9, 1, BLK2, "R6");
    idle();
    // R8: miss on blocked lines is held
    step(0, 0, 0, 1, 1, 4, 0, BLK, "R8");
    step(0, 0, 0, 1, 0, 4, 0, BLK2, "R8");
    // R9: miss on writeback-pending line is recycled
    step(0, 0, 0, 1, 1, 4, 0, WBP, "R9");
    // R11: same-bit set and clear in one cycle, clear wins
    step(1, 4, 2, 0, 0, 0, 0, OPEN, "R11");
    step(1, 4, 2, 1, 1, 4, 2, OPEN, "R11");
    step(0, 0, 0, 1, 1, 4, 2, OPEN, "R11");
    // R11: different bits in one cycle, both take effect
    step(1, 8, 0, 0, 0, 0, 0, OPEN, "R11");
    step(1, 9, 0, 1, 0, 8, 0, OPEN, "R11");
    step(0, 0, 0, 1, 1, 9, 0, OPEN, "R11");
    step(0, 0, 0, 1, 1, 8, 0, OPEN, "R11");
    // R4: back-to-back sunk victims give acks on consecutive cycles
    step(1, 15, 3, 0, 0, 0, 0, OPEN, "R4");
    step(1, 0, 0, 0, 0, 0, 0, OPEN, "R4");
    step(0, 0, 0, 1, 1, 15, 3, BLK, "R4");
    step(0, 0, 0, 1, 0, 0, 0, WBP, "R4");
    idle();
    idle();
    done = 1'b1;
    check("R4", ackQ.size(), 0, "acks left outstanding");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #100000;
    compared++;
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule